// File: doc/BRIEF.md
# Slew-Limited Output Voltage Target Sequencer

This block produces the 6-bit code that sets the reference of a step-down regulator's output. The output voltage is 0.6 V plus the code times 12.5 mV, so codes 0 to 63 span 0.6 V to 1.3875 V. Two stored codes are held outside the block, and a select pin chooses which one is the target. Toggling the pin or rewriting the chosen code starts a transition.

Upward transitions are ramped one code step at a time. A 3-bit rate field sets the pace. Each higher field value doubles the step interval, so the rates run from 80 mV/µs down to 0.625 mV/µs. Downward transitions are not ramped. The code jumps straight to the new value, and a switching-inhibit flag is raised. The flag stays high until an external comparator reports that the load has pulled the output down to the new set point. While the regulator is disabled, the code tracks the target directly and the step timer is held idle.

Top module: `vout_target_seq`

## Requirements
- R1: The target is `code_hi` when `sel_pin` is 1 and `code_lo` when it is 0. The full range of codes, 0 to 63, reaches `code_out`.
- R2: While `rst_n` is low, `code_out` is 0 and `sw_inhibit` is 0.
- R3: While `en` is 0, `code_out` equals the target one cycle later and `sw_inhibit` is 0. A ramp in progress is abandoned when `en` falls.
- R4: While enabled, `code_out` only ever rises by exactly 1 per step and never goes past the target.
- R5: While the target is above the code, a step occurs every BASE_TICKS<<slew clock cycles. The first step comes that many cycles after the target first rises above the code. `slew` is the 3-bit rate field; 0 is the fastest rate, and each higher value doubles the interval.
- R6: While enabled, a target below the present code sets `code_out` to the target on the next cycle and sets `sw_inhibit` to 1.
- R7: `sw_inhibit` stays at 1 until `reached` is sampled high, and it is 0 on the cycle after that. `reached` has no effect while `sw_inhibit` is 0.
- R8: If the target moves higher during a ramp, the ramp continues from the present code, and the step timer is not restarted.
- R9: If the target moves below the present code during a ramp, the block takes the falling behaviour of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable |
| sel_pin | input | 1 | Chooses which stored code is the target |
| code_lo | input | 6 | Stored code used when `sel_pin` is 0 |
| code_hi | input | 6 | Stored code used when `sel_pin` is 1 |
| slew | input | 3 | Rise rate field; the step interval is BASE_TICKS<<slew cycles |
| reached | input | 1 | Comparator flag: the output has fallen to the set point |
| code_out | output | 6 | Present reference code |
| sw_inhibit | output | 1 | Switching inhibited while a falling transition settles |

## Verification
A wrong step-timer count shows up at `code_out` as a step that arrives one or more cycles early or late. The bench samples the cycle before each expected step and the cycle of the step, so a wrong count is seen on the first step of a ramp. A wrong direction decision shows up on the next cycle: either a jump where a single step was expected, or a step where a jump was expected. A stuck or missed inhibit state shows on `sw_inhibit` on the cycle after a fall or after `reached` rises. Retargeting a ramp part-way through exposes a timer that is restarted when it should keep running.

// File: rtl/vts_pkg.sv
package vts_pkg;

  typedef enum logic [1:0] {
    VTS_OFF  = 2'd0,
    VTS_HOLD = 2'd1,
    VTS_RISE = 2'd2,
    VTS_FALL = 2'd3
  } vts_dir_e;

endpackage

// File: rtl/vts_target_mux.sv
module vts_target_mux #(
  parameter int CODE_W = 6
) (
  input  logic              sel_pin,
  input  logic [CODE_W-1:0] code_lo,
  input  logic [CODE_W-1:0] code_hi,
  output logic [CODE_W-1:0] target
);

  always_comb begin
    target = sel_pin ? code_hi : code_lo;
  end

endmodule

// File: rtl/vts_step_timer.sv
module vts_step_timer #(
  parameter int SLEW_W     = 3,
  parameter int BASE_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [SLEW_W-1:0] slew,
  output logic              step
);

  localparam int MAX_SHIFT = (1 << SLEW_W) - 1;
  localparam int MAX_LIM   = BASE_TICKS << MAX_SHIFT;
  localparam int CNT_W     = $clog2(MAX_LIM + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] last;

  // Interval for the selected rate; a shrink mid-ramp is caught by >=
  always_comb begin
    limit = CNT_W'(BASE_TICKS) << slew;
    last  = limit - CNT_W'(1);
    step  = run && (cnt_q >= last);
  end

  always_comb begin
    if (!run || step) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/vts_code_ctrl.sv
module vts_code_ctrl
  import vts_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] target,
  input  logic              step,
  input  logic              reached,
  output logic [CODE_W-1:0] code,
  output logic              inhibit,
  output logic              ramp_run
);

  vts_dir_e          dir;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;
  logic              code_en;
  logic              inh_q;
  logic              inh_d;

  always_comb begin
    if (!en) begin
      dir = VTS_OFF;
    end else if (target > code_q) begin
      dir = VTS_RISE;
    end else if (target < code_q) begin
      dir = VTS_FALL;
    end else begin
      dir = VTS_HOLD;
    end
  end

  always_comb begin
    code_d  = code_q;
    code_en = 1'b0;
    inh_d   = inh_q && !reached;
    unique case (dir)
      VTS_OFF: begin
        code_d  = target;
        code_en = 1'b1;
        inh_d   = 1'b0;
      end
      VTS_FALL: begin
        code_d  = target;
        code_en = 1'b1;
        inh_d   = 1'b1;
      end
      VTS_RISE: begin
        code_d  = code_q + CODE_W'(1);
        code_en = step;
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      inh_q  <= 1'b0;
    end else begin
      if (code_en) begin
        code_q <= code_d;
      end
      inh_q <= inh_d;
    end
  end

  always_comb begin
    code     = code_q;
    inhibit  = inh_q;
    ramp_run = (dir == VTS_RISE);
  end

endmodule

// File: rtl/vout_target_seq.sv
module vout_target_seq #(
  parameter int CODE_W     = 6,
  parameter int SLEW_W     = 3,
  parameter int BASE_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sel_pin,
  input  logic [CODE_W-1:0] code_lo,
  input  logic [CODE_W-1:0] code_hi,
  input  logic [SLEW_W-1:0] slew,
  input  logic              reached,
  output logic [CODE_W-1:0] code_out,
  output logic              sw_inhibit
);

  logic [CODE_W-1:0] target;
  logic              ramp_run;
  logic              step;

  vts_target_mux #(.CODE_W(CODE_W)) u_mux (
    .sel_pin (sel_pin),
    .code_lo (code_lo),
    .code_hi (code_hi),
    .target  (target)
  );

  vts_step_timer #(.SLEW_W(SLEW_W), .BASE_TICKS(BASE_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ramp_run),
    .slew  (slew),
    .step  (step)
  );

  vts_code_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .target   (target),
    .step     (step),
    .reached  (reached),
    .code     (code_out),
    .inhibit  (sw_inhibit),
    .ramp_run (ramp_run)
  );

endmodule

// File: rtl/vts_checker.sv
module vts_checker #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              sel_pin,
  input logic [CODE_W-1:0] code_lo,
  input logic [CODE_W-1:0] code_hi,
  input logic              reached,
  input logic [CODE_W-1:0] code_out,
  input logic              sw_inhibit
);

  logic [CODE_W-1:0] tgt;
  assign tgt = sel_pin ? code_hi : code_lo;

  assert_disabled_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (code_out == $past(tgt)) && !sw_inhibit);

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (code_out > $past(code_out)))
      |-> (({1'b0, code_out}) == ({1'b0, $past(code_out)} + 1'b1))
          && ($past(code_out) < $past(tgt)));

  assert_fall_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (tgt < code_out)) |=> (code_out == $past(tgt)) && sw_inhibit);

  assert_inhibit_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sw_inhibit && reached && !(tgt < code_out)) |=> !sw_inhibit);

  assert_inhibit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sw_inhibit && !reached) |=> sw_inhibit);

  assert_no_spurious_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sw_inhibit && !(tgt < code_out)) |=> !sw_inhibit);

endmodule

bind vout_target_seq vts_checker #(.CODE_W(CODE_W)) u_vts_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .sel_pin    (sel_pin),
  .code_lo    (code_lo),
  .code_hi    (code_hi),
  .reached    (reached),
  .code_out   (code_out),
  .sw_inhibit (sw_inhibit)
);

// File: tb/tb_vout_target_seq.sv
module tb_vout_target_seq;

  localparam int CODE_W = 6;
  localparam int SLEW_W = 3;
  localparam int BASE   = 8;

  typedef struct {
    int    cyc;
    int    code;
    bit    inh;
    string req;
  } exp_t;

  logic              clk;
  logic              rst_n;
  logic              en;
  logic              sel_pin;
  logic [CODE_W-1:0] code_lo;
  logic [CODE_W-1:0] code_hi;
  logic [SLEW_W-1:0] slew;
  logic              reached;
  logic [CODE_W-1:0] code_out;
  logic              sw_inhibit;

  int   cyc;
  int   n_checks;
  int   n_fail;
  exp_t q[$];

  vout_target_seq #(.CODE_W(CODE_W), .SLEW_W(SLEW_W), .BASE_TICKS(BASE)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .sel_pin    (sel_pin),
    .code_lo    (code_lo),
    .code_hi    (code_hi),
    .slew       (slew),
    .reached    (reached),
    .code_out   (code_out),
    .sw_inhibit (sw_inhibit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int c, input int code, input bit inh, input string req);
    exp_t e;
    e.cyc  = c;
    e.code = code;
    e.inh  = inh;
    e.req  = req;
    q.push_back(e);
  endtask

  // Monitor: compare outputs when the expected cycle comes around
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (e.cyc != cyc) begin
        n_fail++;
        $display("FAIL %s: check for cycle %0d missed at cycle %0d", e.req, e.cyc, cyc);
      end else if (int'(code_out) != e.code || sw_inhibit != e.inh) begin
        n_fail++;
        $display("FAIL %s: cycle %0d code=%0d inh=%0b expected code=%0d inh=%0b",
                 e.req, cyc, code_out, sw_inhibit, e.code, e.inh);
      end
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung, actual cycle %0d expected end before it", cyc);
    finish_run();
  end

  initial begin
    int t0;
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    en       = 1'b0;
    sel_pin  = 1'b0;
    code_lo  = 6'd10;
    code_hi  = 6'd20;
    slew     = 3'd0;
    reached  = 1'b0;
    repeat (3) @(negedge clk);
    expect_at(cyc + 1, 0, 0, "R2");
    drain();
    t0 = cyc; rst_n = 1'b1;
    expect_at(t0 + 1, 10, 0, "R3");
    drain();
    t0 = cyc; code_lo = 6'd40;
    expect_at(t0 + 1, 40, 0, "R3");
    drain();
    t0 = cyc; sel_pin = 1'b1;
    expect_at(t0 + 1, 20, 0, "R1");
    drain();

    // R5 fastest rate, R4 no overshoot
    t0 = cyc; en = 1'b1; code_hi = 6'd23;
    expect_at(t0 + BASE - 1, 20, 0, "R5");
    expect_at(t0 + BASE,     21, 0, "R5");
    expect_at(t0 + 2*BASE,   22, 0, "R4");
    expect_at(t0 + 3*BASE,   23, 0, "R4");
    expect_at(t0 + 5*BASE,   23, 0, "R4");
    drain();

    // R5 slower rate
    t0 = cyc; slew = 3'd2; code_hi = 6'd25;
    expect_at(t0 + 4*BASE - 1, 23, 0, "R5");
    expect_at(t0 + 4*BASE,     24, 0, "R5");
    expect_at(t0 + 8*BASE,     25, 0, "R5");
    drain();

    // R6 fall, R7 hold and release
    t0 = cyc; code_hi = 6'd5;
    expect_at(t0 + 1,  5, 1, "R6");
    expect_at(t0 + 10, 5, 1, "R7");
    drain();
    t0 = cyc; reached = 1'b1;
    expect_at(t0 + 1, 5, 0, "R7");
    expect_at(t0 + 5, 5, 0, "R7");
    drain();
    reached = 1'b0;

    // R8 retarget higher mid-ramp
    t0 = cyc; slew = 3'd0; code_hi = 6'd8;
    expect_at(t0 + BASE, 6, 0, "R8");
    drain();
    wait_until(t0 + 12); code_hi = 6'd10;
    expect_at(t0 + 2*BASE - 1, 6, 0, "R8");
    expect_at(t0 + 2*BASE,     7, 0, "R8");
    expect_at(t0 + 5*BASE,    10, 0, "R8");
    drain();

    // R9 retarget lower mid-ramp
    t0 = cyc; code_hi = 6'd20;
    expect_at(t0 + BASE, 11, 0, "R9");
    drain();
    wait_until(t0 + 10); code_hi = 6'd9;
    expect_at(t0 + 11, 9, 1, "R9");
    drain();
    t0 = cyc; reached = 1'b1;
    expect_at(t0 + 1, 9, 0, "R7");
    drain();
    reached = 1'b0;

    // R1 pin toggle starts a ramp; R3 disable abandons it
    t0 = cyc; code_lo = 6'd12; sel_pin = 1'b0;
    expect_at(t0 + BASE, 10, 0, "R1");
    drain();
    wait_until(t0 + 10); en = 1'b0;
    expect_at(t0 + 11, 12, 0, "R3");
    drain();
    t0 = cyc; code_lo = 6'd3;
    expect_at(t0 + 1, 3, 0, "R3");
    drain();

    // R3 disable clears a pending inhibit
    t0 = cyc; en = 1'b1; code_lo = 6'd1;
    expect_at(t0 + 1, 1, 1, "R6");
    drain();
    wait_until(t0 + 3); en = 1'b0;
    expect_at(t0 + 4, 1, 0, "R3");
    drain();

    // R5 slowest rate
    t0 = cyc; slew = 3'd7; en = 1'b1; code_lo = 6'd2;
    expect_at(t0 + BASE*128 - 1, 1, 0, "R5");
    expect_at(t0 + BASE*128,     2, 0, "R5");
    drain();

    // R1 range ends
    t0 = cyc; en = 1'b0; code_lo = 6'd63;
    expect_at(t0 + 1, 63, 0, "R1");
    drain();
    t0 = cyc; en = 1'b1; code_lo = 6'd0;
    expect_at(t0 + 1, 0, 1, "R6");
    drain();

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule